// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and date as packed BCD counters. It is laid out as a small byte-addressed register file, and a host reaches it through a synchronous port. A one-second pulse advances seconds, minutes, hours, day of week, day of month, month and a two-digit year. The day of month follows the length of each month, with a leap February in years divisible by four.

Three control bits let the host work with the counters safely. The freeze bit holds a snapshot so that a multi-byte read is coherent while the counters keep running. The hold bit stops counting and routes host writes into a shadow copy. Clearing it copies that shadow into the live counters in one step, so a new time is loaded atomically. The stop bit halts timekeeping altogether.

Register map: address 0 is control (bit 0 freeze, bit 1 hold, bit 2 stop). Addresses 1 to 7 hold seconds, minutes, hours, day of week, day of month, month and year. Any other address reads zero.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset, control reads 0 and the clock reads 00:00:00, day of week 01, date 01-01-00. Address 0 is control (bit 0 freeze, bit 1 hold, bit 2 stop). Addresses 1 to 7 are seconds, minutes, hours, day of week, day of month, month, year.
- R2: Every field is packed BCD with the tens digit in bits 7:4. Bits above the field's width are dropped on write and read as zero. Widths are seconds 7, minutes 7, hours 6, day of week 3, day of month 6, month 5, year 8.
- R3: A tick at 59 seconds gives 00 and carries into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into the day fields.
- R4: Day of week counts 1 to 7 and wraps to 1.
- R5: Day of month wraps to 01 after day 28, 29, 30 or 31, according to the month. February has 29 days when the year is divisible by 4.
- R6: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: While freeze is set, time reads return the values at the moment it was set, while counting goes on. Once it is cleared, reads show the live time.
- R8: While hold is set, time writes in any order land in a shadow copy that reads back. Clearing hold loads every field into the counters at once.
- R9: A tick that arrives while hold is set is kept. It is applied one cycle after the load, so no second is lost and none is counted twice.
- R10: While stop is set, ticks have no effect. After stop is cleared, ticks count again.
- R11: A time write while hold is clear does not change the time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| we | input | 1 | Register write enable |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |

## Verification
Read data is combinational, so a register written or a counter advanced at a clock edge is visible in the same cycle after that edge. The bench drives on falling edges and samples one nanosecond later, after every edge it relies on. A tick held during hold is the one result due two edges after its cause: the load edge, then one more. The bench reads one full cycle after clearing hold, and again later to confirm that the second is counted only once.

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int NF = 7;
  localparam int SEC = 0, MIN = 1, HR = 2, WDAY = 3, MDAY = 4, MON = 5, YR = 6;

  logic [7:0] cur [NF];
  logic [7:0] shd [NF];
  logic [7:0] nxt [NF];
  logic [2:0] ctrl;
  logic       pend;

  function automatic logic [7:0] fmask(input int i);
    case (i)
      SEC, MIN: return 8'h7f;
      HR, MDAY: return 8'h3f;
      WDAY:     return 8'h07;
      MON:      return 8'h1f;
      default:  return 8'hff;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(input int i);
    return (i == WDAY || i == MDAY || i == MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] inc(input logic [7:0] b);
    return (b[3:0] == 4'd9) ? {b[7:4] + 4'd1, 4'd0} : b + 8'd1;
  endfunction

  wire frz  = ctrl[0];
  wire halt = ctrl[1];
  wire stp  = ctrl[2];

  wire              is_ctl = (addr == '0);
  wire              is_tm  = (addr != '0) && (int'(addr) <= NF);
  wire [2:0]        fidx   = 3'(int'(addr) - 1);
  wire              load   = we && is_ctl && halt && !wdata[1];
  wire              adv    = !halt && !stp && (tick || pend);

  logic [7:0] ybin, last;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    ybin = {4'd0, cur[YR][7:4]} * 8'd10 + {4'd0, cur[YR][3:0]};
    case (cur[MON])
      8'h02:                      last = (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
      default:                    last = 8'h31;
    endcase
    c_min = cur[SEC] == 8'h59;
    c_hr  = c_min && cur[MIN] == 8'h59;
    c_day = c_hr && cur[HR] == 8'h23;
    c_mon = c_day && cur[MDAY] == last;
    c_yr  = c_mon && cur[MON] == 8'h12;
    for (int i = 0; i < NF; i++) nxt[i] = cur[i];
    nxt[SEC] = c_min ? 8'h00 : inc(cur[SEC]);
    if (c_min) nxt[MIN] = c_hr ? 8'h00 : inc(cur[MIN]);
    if (c_hr)  nxt[HR]  = c_day ? 8'h00 : inc(cur[HR]);
    if (c_day) begin
      nxt[WDAY] = (cur[WDAY] == 8'h07) ? 8'h01 : cur[WDAY] + 8'd1;
      nxt[MDAY] = c_mon ? 8'h01 : inc(cur[MDAY]);
    end
    if (c_mon) nxt[MON] = c_yr ? 8'h01 : inc(cur[MON]);
    if (c_yr)  nxt[YR]  = (cur[YR] == 8'h99) ? 8'h00 : inc(cur[YR]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      pend <= 1'b0;
      for (int i = 0; i < NF; i++) begin
        cur[i] <= rst_val(i);
        shd[i] <= rst_val(i);
      end
    end else begin
      if (we && is_ctl) ctrl <= wdata[2:0];

      if (load) begin
        for (int i = 0; i < NF; i++) cur[i] <= shd[i];
        pend <= pend || (tick && !stp);
      end else if (halt) begin
        if (tick && !stp) pend <= 1'b1;
      end else if (adv) begin
        for (int i = 0; i < NF; i++) cur[i] <= nxt[i];
        pend <= tick && pend;
      end

      if (halt) begin
        if (we && is_tm) shd[fidx] <= wdata & fmask(int'(fidx));
      end else if (!frz) begin
        for (int i = 0; i < NF; i++) shd[i] <= cur[i];
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (is_ctl)     rdata = {5'd0, ctrl};
    else if (is_tm) rdata = (frz || halt) ? shd[fidx] : cur[fidx];
  end
endmodule

// File: rtl/bcd_timekeeper_chk.sv
module bcd_timekeeper_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    ctrl,
  input logic          load,
  input logic [7:0]    cur_sec,
  input logic [7:0]    shd_sec,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata
);
  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_sec) == 8'h59 && cur_sec != 8'h59 && !$past(load)) |-> cur_sec == 8'h00);

  assert_sec_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1)) |-> rdata[7] == 1'b0);

  assert_freeze_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[0]) && !$past(ctrl[1])) |-> $stable(shd_sec));

  assert_hold_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[1]) && !$past(load)) |-> $stable(cur_sec));

  assert_stop_no_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl[2]) && !$past(load)) |-> $stable(cur_sec));
endmodule

bind bcd_timekeeper bcd_timekeeper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .load(load),
  .cur_sec(cur[0]), .shd_sec(shd[0]), .addr(addr), .rdata(rdata)
);

// File: tb/sim_bcd_timekeeper.sv
module sim_bcd_timekeeper;
  logic       clk = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  int total = 0, bad = 0;
  bit done = 0;

  bcd_timekeeper #(.AW(3)) u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d: actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] yr, mo, wd, md, hr, mi, se);
    wr(0, 8'h02);
    wr(7, yr); wr(6, mo); wr(4, wd); wr(5, md); wr(3, hr); wr(2, mi); wr(1, se);
    wr(0, 8'h00);
  endtask

  task automatic t_reset();
    rd(0, 8'h00, "R1 ctrl"); rd(1, 8'h00, "R1 sec"); rd(2, 8'h00, "R1 min");
    rd(3, 8'h00, "R1 hour"); rd(4, 8'h01, "R1 wday"); rd(5, 8'h01, "R1 mday");
    rd(6, 8'h01, "R1 mon"); rd(7, 8'h00, "R1 year");
  endtask

  task automatic t_full_rollover();
    wr(0, 8'h02);
    wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h23); wr(5, 8'h31); wr(4, 8'h07); wr(6, 8'h12); wr(7, 8'h99);
    wr(0, 8'h00);
    rd(1, 8'h59, "R8 sec loaded"); rd(7, 8'h99, "R8 year loaded");
    pulse();
    rd(1, 8'h00, "R3 sec wrap"); rd(2, 8'h00, "R3 min wrap"); rd(3, 8'h00, "R3 hour wrap");
    rd(4, 8'h01, "R4 wday wrap"); rd(5, 8'h01, "R5 mday 31 wrap");
    rd(6, 8'h01, "R6 mon wrap"); rd(7, 8'h00, "R6 year wrap");
  endtask

  task automatic t_month_len();
    set_time(8'h24, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59); pulse();
    rd(5, 8'h29, "R5 leap feb 29"); rd(6, 8'h02, "R5 leap feb mon"); rd(4, 8'h04, "R4 wday step");
    set_time(8'h24, 8'h02, 8'h03, 8'h29, 8'h23, 8'h59, 8'h59); pulse();
    rd(5, 8'h01, "R5 leap feb end"); rd(6, 8'h03, "R5 leap feb->mar");
    set_time(8'h23, 8'h02, 8'h03, 8'h28, 8'h23, 8'h59, 8'h59); pulse();
    rd(5, 8'h01, "R5 common feb end"); rd(6, 8'h03, "R5 common feb->mar");
    set_time(8'h23, 8'h04, 8'h03, 8'h30, 8'h23, 8'h59, 8'h59); pulse();
    rd(5, 8'h01, "R5 april end"); rd(6, 8'h05, "R5 apr->may");
    set_time(8'h23, 8'h01, 8'h03, 8'h30, 8'h23, 8'h59, 8'h59); pulse();
    rd(5, 8'h31, "R5 jan 31"); rd(3, 8'h00, "R3 hour to 00");
    set_time(8'h23, 8'h01, 8'h03, 8'h30, 8'h09, 8'h59, 8'h59); pulse();
    rd(3, 8'h10, "R3 hour bcd carry"); rd(2, 8'h00, "R3 min 59->00");
  endtask

  task automatic t_mask();
    wr(0, 8'h02);
    wr(1, 8'hff); wr(3, 8'hff); wr(4, 8'hff); wr(6, 8'hff); wr(7, 8'hff);
    rd(1, 8'h7f, "R2 sec mask"); rd(3, 8'h3f, "R2 hour mask");
    rd(4, 8'h07, "R2 wday mask"); rd(6, 8'h1f, "R2 mon mask"); rd(7, 8'hff, "R2 year full");
    wr(0, 8'h00);
  endtask

  task automatic t_freeze();
    set_time(8'h25, 8'h06, 8'h02, 8'h10, 8'h10, 8'h00, 8'h00);
    wr(0, 8'h01);
    pulse(); pulse(); pulse();
    rd(1, 8'h00, "R7 frozen sec");
    wr(0, 8'h00);
    rd(1, 8'h03, "R7 live after unfreeze");
  endtask

  task automatic t_hold_tick();
    wr(0, 8'h02);
    wr(1, 8'h10);
    pulse();
    rd(1, 8'h10, "R8 shadow readback");
    wr(0, 8'h00);
    rd(1, 8'h11, "R9 held tick applied");
    rd(1, 8'h11, "R9 held tick once");
  endtask

  task automatic t_stop();
    wr(0, 8'h04);
    pulse(); pulse();
    rd(1, 8'h11, "R10 stopped");
    rd(0, 8'h04, "R1 ctrl readback");
    wr(0, 8'h00);
    pulse();
    rd(1, 8'h12, "R10 restart");
  endtask

  task automatic t_ignored();
    wr(1, 8'h33); wr(2, 8'h44);
    rd(1, 8'h12, "R11 sec write ignored"); rd(2, 8'h00, "R11 min write ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_full_rollover();
    t_month_len();
    t_mask();
    t_freeze();
    t_hold_tick();
    t_stop();
    t_ignored();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule